// File: doc/BRIEF.md
# Memory Operand Address Generator

This block turns the addressing fields of a decoded instruction into the 16-bit byte address of a memory operand. It holds the per-thread address registers and reads one of them for register-indirect operands. It scales the offset field by the access size and, in post-increment mode, returns the register value unchanged as the address while writing the advanced value back to the register. Shared-memory reads carry their access mode inside the offset field. For those reads the block also reports the access size and whether the loaded data must be sign-extended.

Illegal combinations are reported on a two-bit error code in the same cycle as the address, and any error cancels the register write-back. The address path is purely combinational. Register updates, whether from post-increment or from the load port the surrounding pipeline uses to set registers, take effect on the next rising clock edge. The memory array itself is outside this block.

Top module: `mem_addr_gen`

## Requirements
- R1: After reset every address register reads as zero.
- R2: A direct operand (`op_indirect`=0, `op_shared`=0) gives `addr` = `op_offset` << `op_size`, taken modulo 2^16, and `acc_size` = `op_size`. `op_sel` and `op_postinc` have no effect, and no error or write-back occurs.
- R3: An indirect operand without post-increment gives `addr` = register[`op_sel`] + (offset << size), taken modulo 2^16.
- R4: Selectors 0, 5 and 6 always read as zero. A load-port write to any of them is ignored.
- R5: With post-increment on selector 1, 2, 3, 4 or 7, `addr` is the register value and `wb_en` is 1. The register becomes register + (offset << size), modulo 2^16, at the next rising edge. If the load port writes the same register in that cycle, the loaded value wins.
- R6: Post-increment on selector 0, 5 or 6 gives `err` = 1 (forbidden post-increment). This error takes precedence over all others.
- R7: For a shared operand (`op_shared`=1), bits [OFFW-1:OFFW-2] of `op_offset` are the mode and the low OFFW-2 bits are the offset. The operand is always register-based and `op_size` is ignored. The modes are: 0 = byte, factor 1, zero-extend; 1 = unsigned half, factor 2; 2 = signed half, factor 2; 3 = word, factor 4. `acc_size` is 0, 1, 1 and 2 for these modes. `ext_sign` is 1 only in mode 2.
- R8: A shared operand in mode 3 whose source kind `op_kind` is not 0 gives `err` = 2 (size). The kinds are: 0 = word, 1 = half of either sign, 2 = unsigned half, 3 = signed half. The size error takes precedence over the sign error.
- R9: Mode 2 with kind 2, or mode 1 with kind 3, gives `err` = 3 (sign). Mode 0 is legal for every kind.
- R10: Whenever `err` is non-zero, `wb_en` is 0 and no register changes. When `op_valid` is 0, `err` is 0 and `wb_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operand is presented this cycle |
| op_shared | input | 1 | Operand is a shared-memory read |
| op_indirect | input | 1 | Operand uses an address register |
| op_postinc | input | 1 | Post-increment mode |
| op_sel | input | SELW | Address register selector |
| op_offset | input | OFFW | Offset field (mode in top two bits when shared) |
| op_size | input | 2 | log2 of access size for non-shared operands |
| op_kind | input | 2 | Source operand kind for shared legality |
| ld_en | input | 1 | Load-port write enable |
| ld_sel | input | SELW | Load-port register selector |
| ld_data | input | AW | Load-port data |
| addr | output | AW | Effective byte address |
| acc_size | output | 2 | log2 of access size |
| ext_sign | output | 1 | Sign-extend the loaded half |
| wb_en | output | 1 | Post-increment write-back takes place |
| wb_sel | output | SELW | Register being written back |
| wb_data | output | AW | Value being written back |
| err | output | 2 | 0 none, 1 post-increment, 2 size, 3 sign |

## Verification
The hardest case to reach is a post-increment write-back that actually commits. The same is true of its collision with a load to the same register, because a register's new value can only be seen through a later indirect operand with a zero offset. The bench walks its vector table with `op_valid` dropped before each rising edge, so the register contents stay fixed while the table runs. Directed sequences then hold an operand across an edge and read the register back in the next cycle. These sequences cover wrap-around, an erroring operand that must leave its register untouched, and a load colliding with a write-back.

// File: rtl/mem_addr_gen.sv
module mem_addr_gen #(
  parameter int AW   = 16,
  parameter int OFFW = 7,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_shared,
  input  logic            op_indirect,
  input  logic            op_postinc,
  input  logic [SELW-1:0] op_sel,
  input  logic [OFFW-1:0] op_offset,
  input  logic [1:0]      op_size,
  input  logic [1:0]      op_kind,
  input  logic            ld_en,
  input  logic [SELW-1:0] ld_sel,
  input  logic [AW-1:0]   ld_data,
  output logic [AW-1:0]   addr,
  output logic [1:0]      acc_size,
  output logic            ext_sign,
  output logic            wb_en,
  output logic [SELW-1:0] wb_sel,
  output logic [AW-1:0]   wb_data,
  output logic [1:0]      err
);
  localparam int NREG  = 1 << SELW;
  localparam int SOFFW = OFFW - 2;
  localparam logic [1:0] E_NONE = 2'd0, E_POSTINC = 2'd1, E_SIZE = 2'd2, E_SIGN = 2'd3;

  function automatic logic is_stored(input logic [SELW-1:0] s);
    return !(s == SELW'(0) || s == SELW'(5) || s == SELW'(6));
  endfunction

  logic [AW-1:0] areg [NREG];
  logic [1:0]    mode;
  logic [AW-1:0] off_raw, scaled, base;
  logic          use_reg, bump;

  assign mode     = op_offset[OFFW-1:OFFW-2];
  assign off_raw  = op_shared ? AW'(op_offset[SOFFW-1:0]) : AW'(op_offset);
  assign acc_size = !op_shared ? op_size :
                    (mode == 2'd3) ? 2'd2 : (mode == 2'd0) ? 2'd0 : 2'd1;
  assign scaled   = off_raw << acc_size;
  assign base     = is_stored(op_sel) ? areg[op_sel] : '0;
  assign use_reg  = op_shared | op_indirect;
  assign bump     = use_reg & op_postinc;
  assign addr     = !use_reg ? scaled : (bump ? base : base + scaled);
  assign ext_sign = op_shared && (mode == 2'd2);

  always_comb begin
    err = E_NONE;
    if (op_valid) begin
      if (bump && !is_stored(op_sel))
        err = E_POSTINC;
      else if (op_shared && mode == 2'd3 && op_kind != 2'd0)
        err = E_SIZE;
      else if (op_shared && ((op_kind == 2'd2 && mode == 2'd2) ||
                             (op_kind == 2'd3 && mode == 2'd1)))
        err = E_SIGN;
    end
  end

  assign wb_en   = op_valid && bump && (err == E_NONE);
  assign wb_sel  = op_sel;
  assign wb_data = base + scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) areg[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (is_stored(SELW'(i))) begin
          if (ld_en && ld_sel == SELW'(i))
            areg[i] <= ld_data;
          else if (wb_en && wb_sel == SELW'(i))
            areg[i] <= wb_data;
        end
      end
    end
  end
endmodule

module mem_addr_gen_chk #(
  parameter int AW   = 16,
  parameter int OFFW = 7,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_shared,
  input logic            op_indirect,
  input logic            op_postinc,
  input logic [SELW-1:0] op_sel,
  input logic [OFFW-1:0] op_offset,
  input logic [1:0]      op_kind,
  input logic            ld_en,
  input logic [SELW-1:0] ld_sel,
  input logic [AW-1:0]   addr,
  input logic [1:0]      acc_size,
  input logic            ext_sign,
  input logic            wb_en,
  input logic [SELW-1:0] wb_sel,
  input logic [AW-1:0]   wb_data,
  input logic [1:0]      err
);
  logic forbidden;
  assign forbidden = (op_sel == SELW'(0)) || (op_sel == SELW'(5)) || (op_sel == SELW'(6));

  assert_no_wb_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 2'd0) |-> !wb_en);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (err == 2'd0 && !wb_en));

  assert_postinc_forbidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_shared || op_indirect) && op_postinc && forbidden) |-> (err == 2'd1));

  assert_size_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_shared && !op_postinc && op_offset[OFFW-1:OFFW-2] == 2'd3 && op_kind != 2'd0)
      |-> (err == 2'd2));

  assert_sign_only_shared_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sign |-> (op_shared && acc_size == 2'd1));

  assert_wb_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(ld_en && ld_sel == wb_sel)) |=>
      (!(op_valid && op_indirect && !op_shared && !op_postinc &&
         op_sel == $past(wb_sel) && op_offset == '0) || addr == $past(wb_data)));
endmodule

bind mem_addr_gen mem_addr_gen_chk #(.AW(AW), .OFFW(OFFW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_shared(op_shared),
  .op_indirect(op_indirect), .op_postinc(op_postinc), .op_sel(op_sel),
  .op_offset(op_offset), .op_kind(op_kind), .ld_en(ld_en), .ld_sel(ld_sel),
  .addr(addr), .acc_size(acc_size), .ext_sign(ext_sign), .wb_en(wb_en),
  .wb_sel(wb_sel), .wb_data(wb_data), .err(err));

// File: tb/test_mem_addr_gen.sv
`timescale 1ns/1ps
module test_mem_addr_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 0, op_shared = 0, op_indirect = 0, op_postinc = 0;
  logic [2:0]  op_sel = 0;
  logic [6:0]  op_offset = 0;
  logic [1:0]  op_size = 0, op_kind = 0;
  logic        ld_en = 0;
  logic [2:0]  ld_sel = 0;
  logic [15:0] ld_data = 0;
  logic [15:0] addr, wb_data;
  logic [1:0]  acc_size, err;
  logic        ext_sign, wb_en;
  logic [2:0]  wb_sel;
  int          n_run = 0, n_fail = 0;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  mem_addr_gen i_mem_addr_gen (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_shared(op_shared),
    .op_indirect(op_indirect), .op_postinc(op_postinc), .op_sel(op_sel),
    .op_offset(op_offset), .op_size(op_size), .op_kind(op_kind), .ld_en(ld_en),
    .ld_sel(ld_sel), .ld_data(ld_data), .addr(addr), .acc_size(acc_size),
    .ext_sign(ext_sign), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data), .err(err));

  // {shared, indirect, postinc, sel, offset, size, kind, exp_addr, exp_err, exp_sign, exp_sz, exp_wb}
  localparam int NV = 23;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,3'd0,7'h05,2'd2,2'd0, 16'h0014,2'd0,1'b0,2'd2,1'b0},
    {1'b0,1'b0,1'b0,3'd0,7'h7F,2'd3,2'd0, 16'h03F8,2'd0,1'b0,2'd3,1'b0},
    {1'b0,1'b1,1'b0,3'd1,7'h03,2'd1,2'd0, 16'h1006,2'd0,1'b0,2'd1,1'b0},
    {1'b0,1'b1,1'b0,3'd2,7'h10,2'd2,2'd0, 16'h0030,2'd0,1'b0,2'd2,1'b0},
    {1'b0,1'b1,1'b0,3'd0,7'h04,2'd0,2'd0, 16'h0004,2'd0,1'b0,2'd0,1'b0},
    {1'b0,1'b1,1'b1,3'd3,7'h02,2'd2,2'd0, 16'h0005,2'd0,1'b0,2'd2,1'b1},
    {1'b0,1'b1,1'b1,3'd7,7'h01,2'd0,2'd0, 16'h0200,2'd0,1'b0,2'd0,1'b1},
    {1'b0,1'b1,1'b1,3'd0,7'h01,2'd0,2'd0, 16'h0000,2'd1,1'b0,2'd0,1'b0},
    {1'b0,1'b1,1'b1,3'd5,7'h01,2'd2,2'd0, 16'h0000,2'd1,1'b0,2'd2,1'b0},
    {1'b0,1'b1,1'b1,3'd6,7'h01,2'd1,2'd0, 16'h0000,2'd1,1'b0,2'd1,1'b0},
    {1'b1,1'b0,1'b0,3'd1,7'h03,2'd3,2'd0, 16'h1003,2'd0,1'b0,2'd0,1'b0},
    {1'b1,1'b0,1'b0,3'd1,7'h24,2'd0,2'd2, 16'h1008,2'd0,1'b0,2'd1,1'b0},
    {1'b1,1'b0,1'b0,3'd1,7'h44,2'd0,2'd3, 16'h1008,2'd0,1'b1,2'd1,1'b0},
    {1'b1,1'b0,1'b0,3'd4,7'h62,2'd0,2'd0, 16'h8008,2'd0,1'b0,2'd2,1'b0},
    {1'b1,1'b0,1'b0,3'd4,7'h62,2'd0,2'd1, 16'h8008,2'd2,1'b0,2'd2,1'b0},
    {1'b1,1'b0,1'b0,3'd1,7'h44,2'd0,2'd2, 16'h1008,2'd3,1'b1,2'd1,1'b0},
    {1'b1,1'b0,1'b0,3'd1,7'h24,2'd0,2'd3, 16'h1008,2'd3,1'b0,2'd1,1'b0},
    {1'b1,1'b0,1'b0,3'd1,7'h62,2'd0,2'd2, 16'h1008,2'd2,1'b0,2'd2,1'b0},
    {1'b1,1'b0,1'b1,3'd0,7'h62,2'd0,2'd2, 16'h0000,2'd1,1'b0,2'd2,1'b0},
    {1'b1,1'b0,1'b0,3'd1,7'h1F,2'd0,2'd3, 16'h101F,2'd0,1'b0,2'd0,1'b0},
    {1'b0,1'b0,1'b1,3'd0,7'h02,2'd2,2'd0, 16'h0008,2'd0,1'b0,2'd2,1'b0},
    {1'b1,1'b0,1'b1,3'd2,7'h7F,2'd0,2'd0, 16'hFFF0,2'd0,1'b0,2'd2,1'b1},
    {1'b1,1'b0,1'b0,3'd2,7'h3F,2'd0,2'd2, 16'h002E,2'd0,1'b0,2'd1,1'b0}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1, 20:   return "R2";
      2, 3:       return "R3";
      4:          return "R4";
      5, 6, 21:   return "R5";
      7, 8, 9, 18: return "R6";
      14, 17:     return "R8";
      15, 16:     return "R9";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic sh, input logic ind, input logic pi, input logic [2:0] sel,
                       input logic [6:0] off, input logic [1:0] sz, input logic [1:0] kind);
    @(negedge clk);
    op_valid = 1; op_shared = sh; op_indirect = ind; op_postinc = pi;
    op_sel = sel; op_offset = off; op_size = sz; op_kind = kind;
  endtask

  task automatic read_reg(input logic [2:0] sel, output logic [15:0] v);
    drive(1'b0, 1'b1, 1'b0, sel, 7'd0, 2'd0, 2'd0);
    #1 v = addr;
    op_valid = 0;
  endtask

  task automatic load(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: registers start at zero
    read_reg(3'd1, rd); check(rd == 16'h0, "R1 a1 after reset", rd, 0);
    read_reg(3'd7, rd); check(rd == 16'h0, "R1 a7 after reset", rd, 0);
    #1 check(err == 0 && !wb_en, "R10 idle outputs", {err, wb_en}, 0);

    load(3'd1, 16'h1000); load(3'd2, 16'hFFF0); load(3'd3, 16'h0005);
    load(3'd4, 16'h8000); load(3'd7, 16'h0200);
    // R4: load to hardwired-zero selectors ignored
    load(3'd0, 16'h1234); load(3'd5, 16'h5555); load(3'd6, 16'h6666);
    read_reg(3'd0, rd); check(rd == 0, "R4 a0 load ignored", rd, 0);
    read_reg(3'd5, rd); check(rd == 0, "R4 a5 load ignored", rd, 0);
    read_reg(3'd6, rd); check(rd == 0, "R4 a6 load ignored", rd, 0);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      logic [21:0] e;
      v = VEC[i];
      e = v[21:0];
      drive(v[38], v[37], v[36], v[35:33], v[32:26], v[25:24], v[23:22]);
      #1;
      check({addr, err, ext_sign, acc_size, wb_en} == e,
            $sformatf("%s vector %0d", vtag(i), i), {10'd0, addr, err, ext_sign, acc_size, wb_en}, {10'd0, e});
      op_valid = 0;
    end

    // R5: post-increment commits at the next edge
    drive(1'b0, 1'b1, 1'b1, 3'd3, 7'd2, 2'd2, 2'd0);
    @(posedge clk); #1 op_valid = 0;
    read_reg(3'd3, rd); check(rd == 16'h000D, "R5 a3 post-increment commit", rd, 16'h000D);

    // R5: wrap on write-back
    drive(1'b0, 1'b1, 1'b1, 3'd2, 7'h7F, 2'd3, 2'd0);
    @(posedge clk); #1 op_valid = 0;
    read_reg(3'd2, rd); check(rd == 16'h03E8, "R5 a2 wrap commit", rd, 16'h03E8);

    // R5: shared post-increment, word mode factor 4
    drive(1'b1, 1'b0, 1'b1, 3'd4, 7'h61, 2'd0, 2'd0);
    @(posedge clk); #1 op_valid = 0;
    read_reg(3'd4, rd); check(rd == 16'h8004, "R5 a4 shared commit", rd, 16'h8004);

    // R10: erroring post-increment leaves register untouched
    drive(1'b1, 1'b0, 1'b1, 3'd1, 7'h61, 2'd0, 2'd1);
    #1 check(err == 2'd2 && !wb_en, "R10 size error no write-back", {err, wb_en}, 3'b100);
    @(posedge clk); #1 op_valid = 0;
    read_reg(3'd1, rd); check(rd == 16'h1000, "R10 a1 unchanged", rd, 16'h1000);

    // R6: forbidden post-increment on a0 changes nothing
    drive(1'b0, 1'b1, 1'b1, 3'd0, 7'd3, 2'd0, 2'd0);
    @(posedge clk); #1 op_valid = 0;
    read_reg(3'd0, rd); check(rd == 0, "R6 a0 stays zero", rd, 0);

    // R5: load wins over write-back on the same register
    drive(1'b0, 1'b1, 1'b1, 3'd7, 7'd1, 2'd0, 2'd0);
    ld_en = 1; ld_sel = 3'd7; ld_data = 16'h1234;
    @(posedge clk); #1 op_valid = 0; ld_en = 0;
    read_reg(3'd7, rd); check(rd == 16'h1234, "R5 load beats write-back", rd, 16'h1234);

    // R10: op_valid low suppresses errors
    @(negedge clk);
    op_valid = 0; op_shared = 0; op_indirect = 1; op_postinc = 1; op_sel = 3'd0;
    #1 check(err == 0 && !wb_en, "R10 invalid operand quiet", {err, wb_en}, 0);
    @(posedge clk); #1;
    read_reg(3'd3, rd); check(rd == 16'h000D, "R10 a3 unchanged while idle", rd, 16'h000D);

    finish_run();
  end
endmodule